// File: doc/BRIEF.md
# I2C Control-Port Slave with Interrupt-Request Handshake

This block is a byte-wide I2C slave for a host control port. A fast system clock oversamples the SCL and SDA lines. Host writes to bus address zero are acknowledged, and each received byte is handed to the core on an 8-bit bus with a one-cycle strobe. The core queues reply bytes into a 16-entry outbound FIFO through a push port. An active-low interrupt request tells the host that reply data is waiting. The host fetches the data with a read addressed by the byte 0x01.

The interrupt request also marks the end of the read. It stays asserted through every queued byte. It is released at the seventh SCL rising edge of the last byte, which is the second-to-last bit. The host then clocks out the final bit, sends a no-acknowledge and a stop. Only one read transaction is allowed. Any bytes still queued when the host ends the read with a no-acknowledge are dropped.

The controller is a single state machine:
- IDLE waits for a start condition.
- ADDR shifts in the address byte.
- ADDR_ACK drives the address acknowledge.
- WR_DATA and WR_ACK receive write bytes and acknowledge each one.
- RD_DATA shifts a reply byte out.
- RD_ACK samples the host acknowledge.
- IGNORE stays off the bus until the next start or stop.

Transitions:
- A start (SDA falls while SCL is high) moves any state to ADDR.
- A stop (SDA rises while SCL is high) moves any state to IDLE.
- The SCL falling edge after the eighth bit moves ADDR to ADDR_ACK on a match, or to IGNORE otherwise.
- The SCL falling edge after the eighth bit moves WR_DATA to WR_ACK and RD_DATA to RD_ACK.
- The SCL falling edge that ends the acknowledge pulse moves ADDR_ACK to WR_DATA or RD_DATA.
- The same edge moves WR_ACK back to WR_DATA.
- The same edge moves RD_ACK to RD_DATA on a host ACK with data left, or to IGNORE otherwise.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: A start condition, seen from any state, begins address reception. A stop condition returns the block to idle from any state, including the middle of a byte. A following transaction then works normally.
- R2: An address byte of 0x00 (address 0, R/W=0) is acknowledged by pulling SDA low on the ninth SCL pulse. Each following write byte is also acknowledged. Each write byte appears on rx_data_o with rx_valid_o high for exactly one system clock.
- R3: An address byte other than 0x00 and 0x01 is not acknowledged. Bytes that follow it up to the next start or stop get no acknowledge and produce no rx_valid_o pulse.
- R4: The address byte 0x01 is acknowledged only when the outbound FIFO holds data. Bytes are then sent MSB first, in push order. With an empty FIFO the address is not acknowledged.
- R5: The block only pulls SDA low, and it never begins pulling while SCL is high. SDA is left released while the host sends data bits.
- R6: intreq_n_o goes low within a few system clocks after a byte is pushed into an empty FIFO. It falls only while the FIFO holds data.
- R7: While a reply byte is shifted out, intreq_n_o stays low. At the seventh SCL rising edge of a byte, intreq_n_o goes high if no further byte is queued, and stays low if one is.
- R8: Once intreq_n_o has gone high at that edge, it stays high until the next SCL rising edge, even if a byte is pushed in between.
- R9: When the host ends a read with a no-acknowledge, every byte still queued is discarded. intreq_n_o returns high, and a later read address is not acknowledged.
- R10: The outbound FIFO holds 16 bytes. Pushes while it is full are dropped, and the first 16 bytes are read back intact.
- R11: After reset, SDA is released, intreq_n_o is high and rx_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |
| intreq_n_o | output | 1 | Active-low request: outbound data pending |
| push_valid_i | input | 1 | Push strobe for the outbound FIFO |
| push_data_i | input | 8 | Byte to queue for the host |
| rx_valid_o | output | 1 | One-cycle strobe for a received write byte |
| rx_data_o | output | 8 | Received write byte |

## Verification
A wrong state in the controller shows on the bus within one SCL bit:
- A mis-decoded address or a lost bit count flips the ninth-pulse acknowledge that the host samples.
- A stale shift register puts a wrong reply bit on the bus at the next SCL high phase.

The interrupt logic is checked at the two SCL edges around the release point and again after a push that lands in the hold window. An early or late release, or a hold that ends too soon, therefore appears within one bit time. A queue that fails to flush shows up at the next read address, as an acknowledge where none is expected.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;
    localparam logic [7:0] ADDR_WRITE = 8'h00;
    localparam logic [7:0] ADDR_READ  = 8'h01;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_DATA,
        S_WR_ACK,
        S_RD_DATA,
        S_RD_ACK,
        S_IGNORE
    } ctl_state_e;
endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl_o  = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
    assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/ctl_out_fifo.sv
module ctl_out_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R10
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R9
endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave
    import i2c_ctrl_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       intreq_n_o,
    input  logic       push_valid_i,
    input  logic [7:0] push_data_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;

    ctl_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
    ctl_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    ctl_state_e st, st_n;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       host_ack, hold, intreq_q;
    logic       pop, flush, fifo_empty, fifo_full;
    logic [7:0] fifo_rd;
    logic       start_det, stop_det, in_read, rel_evt, pending, keep_low;

    ctl_out_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_valid_i), .push_data(push_data_i),
        .pop(pop), .flush(flush), .rd_data(fifo_rd),
        .empty(fifo_empty), .full(fifo_full));

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign in_read   = (st == S_RD_DATA) || (st == S_RD_ACK);

    // next-state logic
    always_comb begin
        st_n  = st;
        pop   = 1'b0;
        flush = 1'b0;
        if (stop_det) begin
            st_n  = S_IDLE;
            flush = in_read;
        end else if (start_det) begin
            st_n  = S_ADDR;
            flush = in_read;
        end else begin
            unique case (st)
                S_IDLE, S_IGNORE: st_n = st;
                S_ADDR: if (scl_fall && bitcnt == 4'd8) begin
                    if (shreg == ADDR_WRITE)                    st_n = S_ADDR_ACK;
                    else if (shreg == ADDR_READ && !fifo_empty) st_n = S_ADDR_ACK;
                    else                                        st_n = S_IGNORE;
                end
                S_ADDR_ACK: if (scl_fall) begin
                    if (shreg[0]) begin
                        st_n = S_RD_DATA;
                        pop  = 1'b1;
                    end else begin
                        st_n = S_WR_DATA;
                    end
                end
                S_WR_DATA: if (scl_fall && bitcnt == 4'd8) st_n = S_WR_ACK;
                S_WR_ACK:  if (scl_fall) st_n = S_WR_DATA;
                S_RD_DATA: if (scl_fall && bitcnt == 4'd8) st_n = S_RD_ACK;
                S_RD_ACK: if (scl_fall) begin
                    if (host_ack && !fifo_empty) begin
                        st_n = S_RD_DATA;
                        pop  = 1'b1;
                    end else begin
                        st_n  = S_IGNORE;
                        flush = 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    assign rel_evt  = (st == S_RD_DATA) && scl_rise && (bitcnt == 4'd6) && fifo_empty;
    assign pending  = !fifo_empty && !flush;
    assign keep_low = !intreq_q && (st == S_RD_DATA) && (bitcnt <= 4'd6) && !flush;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            shreg      <= '0;
            host_ack   <= 1'b0;
            hold       <= 1'b0;
            intreq_q   <= 1'b1;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            rx_valid_o <= 1'b0;
            if (start_det || st_n != st) begin
                bitcnt <= '0;
            end else if (scl_rise && (st == S_ADDR || st == S_WR_DATA || st == S_RD_DATA)) begin
                bitcnt <= bitcnt + 1'b1;
            end

            if (pop) begin
                shreg <= fifo_rd;
            end else if ((st == S_ADDR || st == S_WR_DATA) && scl_rise) begin
                shreg <= {shreg[6:0], sda_lvl};
            end else if (st == S_RD_DATA && scl_fall && bitcnt != 4'd0 && bitcnt != 4'd8) begin
                shreg <= {shreg[6:0], 1'b0};
            end

            if (st == S_WR_DATA && st_n == S_WR_ACK) begin
                rx_valid_o <= 1'b1;
                rx_data_o  <= shreg;
            end

            if (st == S_RD_ACK && scl_rise) host_ack <= ~sda_lvl;

            if (rel_evt)       hold <= 1'b1;
            else if (scl_rise) hold <= 1'b0;

            if (rel_evt || hold)          intreq_q <= 1'b1;
            else if (pending || keep_low) intreq_q <= 1'b0;
            else                          intreq_q <= 1'b1;
        end
    end

    assign sda_pull_o = (st == S_ADDR_ACK) || (st == S_WR_ACK) ||
                        ((st == S_RD_DATA) && !shreg[7]);
    assign intreq_n_o = intreq_q;

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl); // R5
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R2
    AST_IRQ_FALL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intreq_n_o) |-> $past(!fifo_empty)); // R6
    AST_IRQ_RISE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intreq_n_o) |-> $past(fifo_empty || flush)); // R7
    AST_NO_PULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IGNORE) |-> !rx_valid_o || $past(st == S_WR_DATA)); // R3
endmodule

// File: tb/tb_i2c_ctrl_slave.sv
module tb_i2c_ctrl_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic host_scl = 1'b1, host_low = 1'b0;
    logic sda_pull, intreq_n, push_valid = 1'b0, rx_valid;
    logic [7:0] push_data = '0, rx_data;
    wire sda_line = !(host_low || sda_pull);

    i2c_ctrl_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .intreq_n_o(intreq_n),
        .push_valid_i(push_valid), .push_data_i(push_data),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data));

    int checks = 0, fails = 0, rx_cnt = 0, wr_err = 0;
    logic [7:0] rx_last;
    logic [7:0] model_q [$];
    bit done = 0;

    always @(negedge clk) if (rx_valid) begin
        rx_cnt++;
        rx_last = rx_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic bit model_push(input logic [7:0] b);
        if (model_q.size() < 16) begin
            model_q.push_back(b);
            return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic push(input logic [7:0] b);
        @(posedge clk); #1;
        push_valid = 1'b1; push_data = b;
        @(posedge clk); #1;
        push_valid = 1'b0;
        void'(model_push(b));
    endtask

    task automatic h_start();
        host_low = 1'b0; w(5); host_scl = 1'b1; w(10);
        host_low = 1'b1; w(10); host_scl = 1'b0; w(5);
    endtask

    task automatic h_stop();
        host_scl = 1'b0; w(3); host_low = 1'b1; w(7);
        host_scl = 1'b1; w(10); host_low = 1'b0; w(10);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            w(3); host_low = ~b[i]; w(7); host_scl = 1'b1; w(5);
            if (sda_line !== b[i]) wr_err++;
            w(5); host_scl = 1'b0;
        end
        w(3); host_low = 1'b0; w(7); host_scl = 1'b1; w(8);
        ack = !sda_line; w(2); host_scl = 1'b0;
    endtask

    task automatic rd_byte(input bit nack, input bit push_mid, input logic [7:0] pb,
                           output logic [7:0] b, output logic [3:0] irq);
        for (int i = 7; i >= 0; i--) begin
            host_low = 1'b0; w(10);
            if (i == 1) irq[0] = intreq_n;
            if (i == 0) irq[2] = intreq_n;
            host_scl = 1'b1; w(8);
            b[i] = sda_line;
            if (i == 1) irq[1] = intreq_n;
            if (i == 0) irq[3] = intreq_n;
            w(2); host_scl = 1'b0;
            if (i == 1 && push_mid) push(pb);
        end
        w(3); host_low = !nack; w(7); host_scl = 1'b1; w(10);
        host_scl = 1'b0; w(3); host_low = 1'b0;
    endtask

    task automatic read_all(input int n, input string req);
        bit ack;
        logic [7:0] b;
        logic [3:0] irq;
        h_start();
        wr_byte(8'h01, ack);
        chk(ack, {req, " R4 read addr ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            e = model_q.pop_front();
            rd_byte(k == n - 1, 1'b0, 8'h00, b, irq);
            chk(b == e, {req, " R4 data MSB-first"}, b, e);
            if (k == n - 1) begin
                chk(irq[0] == 1'b0, {req, " R7 low before 7th rise"}, irq[0], 0);
                chk(irq[1] == 1'b1, {req, " R7 high after 7th rise"}, irq[1], 1);
            end else begin
                chk(irq[1] == 1'b0, {req, " R7 stays low with more queued"}, irq[1], 0);
            end
        end
        h_stop();
        model_q.delete();
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        logic [3:0] irq;
        int c0;
        void'($urandom(32'h5EED1));
        w(5); rst_n = 1'b1; w(5);
        chk(sda_pull == 1'b0, "R11 sda released", sda_pull, 0);
        chk(intreq_n == 1'b1, "R11 intreq high", intreq_n, 1);
        chk(rx_valid == 1'b0, "R11 rx_valid low", rx_valid, 0);

        // directed write, random data
        h_start();
        wr_byte(8'h00, ack);
        chk(ack, "R2 write addr ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            c0 = rx_cnt;
            wr_byte(d, ack);
            chk(ack, "R2 data ack", ack, 1);
            chk(rx_cnt == c0 + 1 && rx_last == d, "R2 rx strobe data", rx_last, d);
        end
        h_stop();
        chk(wr_err == 0, "R5 sda released while host drives", wr_err, 0);

        // foreign address
        c0 = rx_cnt;
        h_start();
        wr_byte(8'h5A, ack);
        chk(!ack, "R3 foreign addr nack", ack, 0);
        wr_byte(8'h00, ack);
        chk(!ack && rx_cnt == c0, "R3 following byte ignored", rx_cnt, c0);
        h_stop();

        // read with empty queue
        h_start();
        wr_byte(8'h01, ack);
        chk(!ack, "R4 empty read nack", ack, 0);
        h_stop();

        // random read
        begin
            int n;
            n = 3 + int'($urandom % 4);
            for (int k = 0; k < n; k++) push(8'($urandom));
            w(6);
            chk(intreq_n == 1'b0, "R6 intreq low when pending", intreq_n, 0);
            read_all(n, "rand");
            w(4);
            chk(intreq_n == 1'b1, "R7 intreq high after read", intreq_n, 1);
        end

        // early end discards
        for (int k = 0; k < 5; k++) push(8'($urandom));
        h_start();
        wr_byte(8'h01, ack);
        rd_byte(1'b0, 1'b0, 8'h00, b, irq);
        chk(b == model_q[0], "R9 first byte", b, model_q[0]);
        rd_byte(1'b1, 1'b0, 8'h00, b, irq);
        chk(b == model_q[1], "R9 second byte", b, model_q[1]);
        h_stop();
        model_q.delete();
        w(4);
        chk(intreq_n == 1'b1, "R9 intreq high after discard", intreq_n, 1);
        h_start();
        wr_byte(8'h01, ack);
        chk(!ack, "R9 queue emptied", ack, 0);
        h_stop();

        // full FIFO
        for (int k = 0; k < 18; k++) push(8'($urandom));
        chk(model_q.size() == 16, "R10 model depth", model_q.size(), 16);
        read_all(16, "R10 full");

        // hold window
        push(8'hA5);
        h_start();
        wr_byte(8'h01, ack);
        rd_byte(1'b0, 1'b1, 8'h3C, b, irq);
        chk(b == 8'hA5, "R8 byte", b, 8'hA5);
        chk(irq[1] == 1'b1, "R7 release at 7th rise", irq[1], 1);
        chk(irq[2] == 1'b1, "R8 held high despite push", irq[2], 1);
        chk(irq[3] == 1'b0, "R8 low again after next rise", irq[3], 0);
        rd_byte(1'b1, 1'b0, 8'h00, b, irq);
        chk(b == 8'h3C, "R8 pushed byte read", b, 8'h3C);
        h_stop();
        model_q.delete();

        // stop mid-byte, then start inside address
        h_start();
        wr_byte(8'h00, ack);
        for (int i = 0; i < 4; i++) begin
            w(3); host_low = 1'b0; w(7); host_scl = 1'b1; w(10); host_scl = 1'b0;
        end
        h_stop();
        h_start();
        for (int i = 0; i < 3; i++) begin
            w(3); host_low = 1'b1; w(7); host_scl = 1'b1; w(10); host_scl = 1'b0;
        end
        h_start();
        c0 = rx_cnt;
        wr_byte(8'h00, ack);
        chk(ack, "R1 addr ack after stop and restart", ack, 1);
        wr_byte(8'h96, ack);
        chk(rx_cnt == c0 + 1 && rx_last == 8'h96, "R1 write after recovery", rx_last, 8'h96);
        h_stop();

        // random mix
        for (int it = 0; it < 4; it++) begin
            int n;
            n = 1 + int'($urandom % 5);
            for (int k = 0; k < n; k++) push(8'($urandom));
            read_all(n, "mix");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule